// File: doc/BRIEF.md
# Four-Mode Barrel Shift Unit

This block is the shifter of a RISC execute stage. It takes a 32-bit operand and produces one registered 32-bit result. The result is the operand shifted right with zero fill, shifted right with sign fill, shifted left with zero fill, or rotated left. The opcode picks which of the four is done. An opcode outside the four shift codes leaves the result register as it was. Fetching register values and writing the result back are handled by the surrounding pipeline.

The shift distance has two sources. A 5-bit count field in the instruction is used when it is nonzero. When that field is zero, the count comes from the low 5 bits of a second register value instead, so a zero field does not mean "do nothing". The distance is applied through five cascaded stages that move the value by 1, 2, 4, 8 and 16 places. Each stage is enabled by one bit of the resolved count. The result is captured on the rising clock edge of any cycle in which `issue` is high.

Top module: `shift_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted shift, `result` reads 0.
- R2: Opcode 26 gives a logical right shift. Result bits 31-n..0 are operand bits 31..n, and the top n bits are 0.
- R3: Opcode 27 gives an arithmetic right shift. The top n bits are copies of operand bit 31. For example, 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R4: Opcode 28 gives a logical left shift. Result bits 31..n are operand bits 31-n..0, and the low n bits are 0.
- R5: Opcode 29 gives a left rotate. Result bits 31..n are operand bits 31-n..0, and the low n bits are operand bits 31..32-n.
- R6: When `shamt_imm` (bits 4..0 of the count field) is nonzero, n equals `shamt_imm`, and `count_src` has no effect.
- R7: When `shamt_imm` is zero, n equals `count_src[4:0]`, and bits 31..5 of `count_src` have no effect.
- R8: When the resolved n is 0, every one of the four modes returns the operand unchanged.
- R9: A shift presented with `issue` high appears on `result` right after the next rising clock edge (a latency of one cycle).
- R10: While `issue` is low, `result` keeps its value whatever the other inputs do.
- R11: An opcode other than 26 to 29, presented with `issue` high, leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| issue | input | 1 | Clock enable; when high, the operation on the inputs is accepted |
| opcode | input | 5 | Operation code; 26 to 29 select the four shift modes |
| shamt_imm | input | 5 | Count field from the instruction |
| operand | input | 32 | Value to be shifted |
| count_src | input | 32 | Register value whose low 5 bits supply the count when `shamt_imm` is zero |
| result | output | 32 | Registered shift result |

## Verification
The assertions compare `result` with the inputs of the previous cycle. They therefore rely on those inputs staying stable from the falling edge, where the bench drives them, to the next rising edge, and on `issue` being a clean level at that edge. The bench changes inputs only at falling edges and holds them across the capturing edge. It waits for the internal reset synchronizer to release before it issues any operation. The sweeps cover both count sources. In the register-sourced cases the upper bits of `count_src` are filled with a busy pattern, so that leaking them into the count would change the result.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [1:0] {
    SH_LSR = 2'd0,
    SH_ASR = 2'd1,
    SH_LSL = 2'd2,
    SH_ROL = 2'd3
  } shift_mode_e;

  localparam int unsigned OPC_W          = 5;
  localparam int unsigned OPC_SHIFT_BASE = 26;
  localparam int unsigned NUM_MODES      = 4;

endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] imm_cnt,
  input  logic [CW-1:0] reg_cnt,
  output logic [CW-1:0] cnt
);

  logic imm_zero;

  always_comb begin
    imm_zero = (imm_cnt == '0);
    cnt      = imm_zero ? reg_cnt : imm_cnt;
  end

endmodule

// File: rtl/shift_stage.sv
module shift_stage
  import shift_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned DIST = 1
) (
  input  logic [W-1:0] din,
  input  shift_mode_e  mode,
  input  logic         en,
  output logic [W-1:0] dout
);

  logic [W-1:0] moved;
  logic         sign_bit;

  always_comb begin
    sign_bit = din[W-1];
    unique case (mode)
      SH_LSR:  moved = {{DIST{1'b0}}, din[W-1:DIST]};
      SH_ASR:  moved = {{DIST{sign_bit}}, din[W-1:DIST]};
      SH_LSL:  moved = {din[W-1-DIST:0], {DIST{1'b0}}};
      default: moved = {din[W-1-DIST:0], din[W-1:W-DIST]};
    endcase
    dout = en ? moved : din;
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [OPC_W-1:0] opcode,
  input  logic [CW-1:0]    shamt_imm,
  input  logic [W-1:0]     operand,
  input  logic [W-1:0]     count_src,
  output logic [W-1:0]     result
);

  localparam int unsigned NSTG = CW;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // opcode decode
  logic        is_shift;
  shift_mode_e mode;
  logic [OPC_W-1:0] opc_off;

  always_comb begin
    opc_off  = opcode - OPC_W'(OPC_SHIFT_BASE);
    is_shift = (opcode >= OPC_W'(OPC_SHIFT_BASE)) &&
               (opcode <  OPC_W'(OPC_SHIFT_BASE + NUM_MODES));
    mode     = shift_mode_e'(opc_off[1:0]);
  end

  // count resolution
  logic [CW-1:0] cnt_res;
  logic [W-CW-1:0] cnt_hi_unused;
  assign cnt_hi_unused = count_src[W-1:CW];

  shift_count_sel #(.CW(CW)) u_cnt (
    .imm_cnt (shamt_imm),
    .reg_cnt (count_src[CW-1:0]),
    .cnt     (cnt_res)
  );

  // cascaded stages of 1, 2, 4, ... positions
  logic [W-1:0] lvl [0:NSTG];
  assign lvl[0] = operand;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    shift_stage #(.W(W), .DIST(1 << s)) u_stg (
      .din  (lvl[s]),
      .mode (mode),
      .en   (cnt_res[s]),
      .dout (lvl[s+1])
    );
  end

  // result register
  logic [W-1:0] result_q, result_nxt;
  logic         load_en;

  always_comb begin
    load_en    = issue && is_shift;
    result_nxt = load_en ? lvl[NSTG] : result_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) result_q <= '0;
    else             result_q <= result_nxt;
  end

  assign result = result_q;

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue |=> $stable(result));

  // R11
  nonshift_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && !is_shift) |=> $stable(result));

  // R8
  zero_count_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && is_shift && shamt_imm == '0 && count_src[CW-1:0] == '0)
      |=> (result == $past(operand)));

  // R5
  rotate_popcount_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && is_shift && mode == SH_ROL)
      |=> ($countones(result) == $countones($past(operand))));

  // R2
  lsr_not_larger_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && is_shift && mode == SH_LSR) |=> (result <= $past(operand)));

  // R3
  asr_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && is_shift && mode == SH_ASR)
      |=> (result[W-1] == $past(operand[W-1])));

  // R4
  lsl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue && is_shift && mode == SH_LSL && cnt_res != '0) |=> (result[0] == 1'b0));

endmodule

// File: tb/shift_unit_tb.sv
module shift_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [4:0]  opcode;
  logic [4:0]  shamt_imm;
  logic [31:0] operand;
  logic [31:0] count_src;
  logic [31:0] result;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  shift_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .opcode    (opcode),
    .shamt_imm (shamt_imm),
    .operand   (operand),
    .count_src (count_src),
    .result    (result)
  );

  function automatic logic [31:0] model(input int m, input logic [31:0] v, input int n);
    logic [63:0] dbl;
    case (m)
      0: return v >> n;
      1: return 32'($signed(v) >>> n);
      2: return v << n;
      default: begin
        dbl = {v, v} << n;
        return dbl[63:32];
      end
    endcase
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive at falling edge, captured at next rising edge, sampled at next falling edge
  task automatic do_op(input logic [4:0] opc, input logic [4:0] imm,
                       input logic [31:0] val, input logic [31:0] csrc);
    @(negedge clk);
    issue = 1'b1; opcode = opc; shamt_imm = imm; operand = val; count_src = csrc;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; issue = 1'b0; opcode = '0; shamt_imm = '0;
    operand = '0; count_src = '0;
    repeat (3) @(negedge clk);
    check("R1 during reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", result, 32'h0);
  endtask

  task automatic t_sweep_imm(input logic [31:0] val);
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n < 32; n++) begin
        // R6: count_src low bits differ from imm, must have no effect
        do_op(5'(26 + m), 5'(n), val, 32'hFFFF_FFE0 | 32'((n + 7) % 32));
        check({tag_of(m), " R6 R9 imm"}, result, model(m, val, n));
      end
    end
  endtask

  task automatic t_sweep_reg(input logic [31:0] val);
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 32; n++) begin
        // R7: upper bits of count_src busy, imm zero
        do_op(5'(26 + m), 5'd0, val, 32'hA5A5_A5A0 ^ 32'(n) ^ 32'h5A00_0000);
        check({tag_of(m), " R7 reg"}, result, model(m, val, (n ^ 0) & 31));
      end
    end
  endtask

  task automatic t_asr_example();
    do_op(5'd27, 5'd13, 32'h97EA_EC16, 32'h0);
    check("R3 example", result, 32'hFFFC_BF57);
  endtask

  task automatic t_zero_count();
    for (int m = 0; m < 4; m++) begin
      do_op(5'(26 + m), 5'd0, 32'hC003_1E5B, 32'hFFFF_FFE0);
      check("R8 zero count", result, 32'hC003_1E5B);
    end
  endtask

  task automatic t_hold_idle();
    do_op(5'd28, 5'd4, 32'h0000_00F1, 32'h0);
    check("R9 load", result, 32'h0000_0F10);
    @(negedge clk);
    issue = 1'b0; opcode = 5'd26; shamt_imm = 5'd1; operand = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R10 idle hold", result, 32'h0000_0F10);
  endtask

  task automatic t_nonshift();
    do_op(5'd26, 5'd8, 32'h1234_5678, 32'h0);
    check("R2 preload", result, 32'h0012_3456);
    do_op(5'd12, 5'd3, 32'hDEAD_BEEF, 32'h0);
    check("R11 opcode 12", result, 32'h0012_3456);
    do_op(5'd30, 5'd3, 32'hDEAD_BEEF, 32'h0);
    check("R11 opcode 30", result, 32'h0012_3456);
    do_op(5'd25, 5'd3, 32'hDEAD_BEEF, 32'h0);
    check("R11 opcode 25", result, 32'h0012_3456);
  endtask

  initial begin
    t_reset();
    t_asr_example();
    t_sweep_imm(32'h97EA_EC16);
    t_sweep_imm(32'h4000_0001);
    t_sweep_reg(32'h8000_0003);
    t_sweep_reg(32'h6B3C_9D21);
    t_zero_count();
    t_hold_idle();
    t_nonshift();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule